// File: doc/BRIEF.md
# Single-Wire EEPROM Command Sequencer

This block is the byte-level protocol engine of a single-wire serial EEPROM slave. A bit transceiver feeds it events: a finished start header, a standby pulse, a received byte, and the master acknowledge bit that follows each byte. The block checks the device address, decodes the command, and collects the word-address and data bytes. For every acknowledge slot it decides whether the slave acknowledges. It hands write data and actions to the memory/status controller, and it presents the byte to send on reads.

The block holds a current-address counter that drives the read address. Sequential reads and current-address reads use it. Once a byte has been received, the master acknowledge that follows picks the next step. A stop (0) at a legal point is a clean end: the slave acknowledges and goes to standby. A stop or continue (1) that the command does not allow sends the block to an error idle state. Only a standby pulse clears that state.

Top module: `sw_cmd_seq`

## Requirements
- R1: Only device address byte 0xA0 is accepted. On a match the next master acknowledge gets a slave acknowledge. Any other value moves `state_o` to idle (2) at once, and that slot gets no slave acknowledge.
- R2: The accepted command codes are 0x03 (read), 0x06 (current-address read), 0x6C (write), 0x96 (set enable), 0x91 (clear enable), 0x05 (status read), 0x6E (status write), 0x6D (fill zero) and 0x67 (fill ones). Any other code sends the block to idle, and the block gives no slave acknowledge.
- R3: While `busy` is 1, codes 0x03, 0x06, 0x6C, 0x6E, 0x6D and 0x67 send the block to idle. Codes 0x96, 0x91 and 0x05 are still accepted.
- R4: Read and write take two word-address bytes, high byte first. The high byte is ignored. On the continue acknowledge after the low byte, `rd_addr` is loaded with the low byte, and `tx_data` shows the memory byte at that address.
- R5: During a read or current-address read, the acknowledge after each data byte (continue or stop) increments `rd_addr`, and 0xFF wraps to 0x00. A current-address read starts at the present counter value.
- R6: A standby pulse returns `state_o` to standby (0) from any state and leaves the counter unchanged.
- R7: Codes 0x96, 0x91, 0x6D and 0x67 followed by a stop get a slave acknowledge, a one-cycle `op_valid`, and standby. `op_code` is 1, 2, 4 and 5 respectively. A continue gives idle, no slave acknowledge and no action.
- R8: Status write (0x6E), after its one data byte, takes a stop: slave acknowledge, `op_valid` with `op_code` 3, and `op_data` equal to the byte. A continue gives idle with no slave acknowledge and no action.
- R9: During a status read, `tx_data` follows `status_in` live. A continue is acknowledged and the block stays active. A stop is acknowledged and the block goes to standby.
- R10: Each write data byte produces `ld_valid` with `ld_addr` equal to the counter and `ld_data` equal to the byte. Afterwards the low 4 counter bits increment and wrap within the 16-byte page. The final stop also gives `op_valid` with `op_code` 6.
- R11: A stop after the header, after a read or write command byte, or after a word-address byte gives no slave acknowledge and idle. A stop right after a matching device address is acknowledged and gives standby.
- R12: `state_o` is 0 in standby, 1 while active and 2 in idle. Idle ignores headers, bytes and acknowledges. From standby, a new header starts a command without a standby pulse.
- R13: The acknowledge slot after the start header never gets a slave acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| hdr_done | input | 1 | start header finished (pulse) |
| stby_pulse | input | 1 | standby pulse seen (pulse) |
| rx_valid | input | 1 | master byte received (pulse) |
| rx_byte | input | 8 | received byte |
| mak_valid | input | 1 | master acknowledge bit received (pulse) |
| mak_bit | input | 1 | 1 continue, 0 stop |
| busy | input | 1 | write cycle in progress |
| status_in | input | 8 | live status byte |
| mem_rd_data | input | 8 | array byte at `rd_addr` |
| sak | output | 1 | slave acknowledge for the last slot (pulse) |
| state_o | output | 2 | 0 standby, 1 active, 2 idle |
| rd_addr | output | ADDR_W | current-address counter |
| tx_data | output | 8 | byte to transmit |
| ld_valid | output | 1 | write data byte strobe |
| ld_addr | output | ADDR_W | write data address |
| ld_data | output | 8 | write data byte |
| op_valid | output | 1 | action strobe |
| op_code | output | 3 | action kind |
| op_data | output | 8 | status write value |

## Verification
All registered results appear in the cycle after the clock edge that captures the input pulse. These are `sak`, `op_*`, `ld_*`, `rd_addr` and `state_o` changes. The bench drives each pulse for one cycle from a falling edge and samples at the following falling edge, so exactly one rising edge separates stimulus from check. `tx_data` is combinational on the counter and `status_in`, so it is read in the same half-cycle as its cause.

// File: rtl/sw_cmd_seq.sv
module sw_cmd_seq #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter logic [7:0] DEV_ID = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_done,
  input  logic              stby_pulse,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              mak_valid,
  input  logic              mak_bit,
  input  logic              busy,
  input  logic [7:0]        status_in,
  input  logic [7:0]        mem_rd_data,
  output logic              sak,
  output logic [1:0]        state_o,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        tx_data,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [7:0]        ld_data,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic [7:0]        op_data
);
  localparam logic [7:0] C_RD = 8'h03, C_CR = 8'h06, C_WR = 8'h6C, C_SE = 8'h96,
                         C_CE = 8'h91, C_SR = 8'h05, C_SW = 8'h6E, C_F0 = 8'h6D,
                         C_F1 = 8'h67;
  localparam int HI_W = ADDR_W - PAGE_W;

  typedef enum logic [3:0] {P_STBY, P_HDR, P_DEV, P_CMD, P_AHI, P_ALO, P_RX, P_TX, P_IDLE} ph_t;
  ph_t ph;
  logic       got;
  logic [7:0] dat, cmd;
  logic [ADDR_W-1:0] cnt;

  function automatic logic known(input logic [7:0] c);
    return c inside {C_RD, C_CR, C_WR, C_SE, C_CE, C_SR, C_SW, C_F0, C_F1};
  endfunction
  function automatic logic blocked(input logic [7:0] c);
    return c inside {C_RD, C_CR, C_WR, C_SW, C_F0, C_F1};
  endfunction
  function automatic logic [2:0] single_op(input logic [7:0] c);
    case (c)
      C_SE: return 3'd1;
      C_CE: return 3'd2;
      C_F0: return 3'd4;
      C_F1: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  assign state_o = (ph == P_STBY) ? 2'd0 : (ph == P_IDLE) ? 2'd2 : 2'd1;
  assign rd_addr = cnt;
  assign tx_data = (cmd == C_SR) ? status_in : mem_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_STBY; got <= 1'b0; dat <= '0; cmd <= '0; cnt <= '0;
      sak <= 1'b0; ld_valid <= 1'b0; ld_addr <= '0; ld_data <= '0;
      op_valid <= 1'b0; op_code <= '0; op_data <= '0;
    end else begin
      sak <= 1'b0; ld_valid <= 1'b0; op_valid <= 1'b0;
      if (stby_pulse) begin
        ph <= P_STBY; got <= 1'b0;
      end else begin
        case (ph)
          P_STBY: if (hdr_done) ph <= P_HDR;
          P_HDR:  if (mak_valid) ph <= mak_bit ? P_DEV : P_IDLE;
          P_IDLE: ;
          P_TX: if (mak_valid) begin
            sak <= 1'b1;
            if (cmd != C_SR) cnt <= cnt + 1'b1;
            ph <= mak_bit ? P_TX : P_STBY;
          end
          default: begin
            if (rx_valid && !got) begin
              dat <= rx_byte; got <= 1'b1;
              if (ph == P_DEV && rx_byte != DEV_ID) ph <= P_IDLE;
              if (ph == P_CMD) begin
                cmd <= rx_byte;
                if (!known(rx_byte) || (busy && blocked(rx_byte))) ph <= P_IDLE;
              end
            end else if (mak_valid) begin
              got <= 1'b0;
              if (!got) ph <= P_IDLE;
              else case (ph)
                P_DEV: begin sak <= 1'b1; ph <= mak_bit ? P_CMD : P_STBY; end
                P_CMD: begin
                  if (single_op(cmd) != 3'd0) begin
                    if (!mak_bit) begin
                      sak <= 1'b1; op_valid <= 1'b1; op_code <= single_op(cmd); ph <= P_STBY;
                    end else ph <= P_IDLE;
                  end else if (!mak_bit) ph <= P_IDLE;
                  else begin
                    sak <= 1'b1;
                    ph <= (cmd == C_RD || cmd == C_WR) ? P_AHI :
                          (cmd == C_SW) ? P_RX : P_TX;
                  end
                end
                P_AHI: if (mak_bit) begin sak <= 1'b1; ph <= P_ALO; end else ph <= P_IDLE;
                P_ALO: if (mak_bit) begin
                  sak <= 1'b1; cnt <= dat[ADDR_W-1:0];
                  ph <= (cmd == C_RD) ? P_TX : P_RX;
                end else ph <= P_IDLE;
                P_RX: begin
                  if (cmd == C_SW) begin
                    if (!mak_bit) begin
                      sak <= 1'b1; op_valid <= 1'b1; op_code <= 3'd3; op_data <= dat; ph <= P_STBY;
                    end else ph <= P_IDLE;
                  end else begin
                    sak <= 1'b1; ld_valid <= 1'b1; ld_addr <= cnt; ld_data <= dat;
                    cnt <= {cnt[ADDR_W-1:PAGE_W], cnt[PAGE_W-1:0] + 1'b1};
                    if (!mak_bit) begin
                      op_valid <= 1'b1; op_code <= 3'd6; ph <= P_STBY;
                    end
                  end
                end
                default: ph <= P_IDLE;
              endcase
            end
          end
        endcase
      end
    end
  end

  // R7
  op_with_sak_chk: assert property (@(posedge clk) disable iff (!rst_n) op_valid |-> sak);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !stby_pulse) |=> state_o == 2'd2);
  // R6
  stby_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby_pulse |=> (state_o == 2'd0 && !sak && $stable(rd_addr)));
  // R13
  sak_source_chk: assert property (@(posedge clk) disable iff (!rst_n) sak |-> $past(mak_valid));
  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !mak_valid |=> $stable(rd_addr));
  // R10
  page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ld_addr[ADDR_W-1:PAGE_W] == rd_addr[ADDR_W-1:PAGE_W]);
  initial assert (HI_W > 0 && ADDR_W <= 8) else $error("bad widths");
endmodule

// File: tb/sw_cmd_seq_bench.sv
module sw_cmd_seq_bench;
  localparam int CLK_PER = 10;
  logic clk = 0, rst_n = 0;
  logic hdr_done = 0, stby_pulse = 0, rx_valid = 0, mak_valid = 0, mak_bit = 0, busy = 0;
  logic [7:0] rx_byte = 0, status_in = 0, mem_rd_data, tx_data, ld_data, op_data;
  logic sak, ld_valid, op_valid;
  logic [1:0] state_o;
  logic [7:0] rd_addr, ld_addr;
  logic [2:0] op_code;
  int total = 0, bad = 0;

  always #(CLK_PER/2) clk = ~clk;
  assign mem_rd_data = rd_addr ^ 8'h5A;

  sw_cmd_seq u_sw_cmd_seq (.clk, .rst_n, .hdr_done, .stby_pulse, .rx_valid, .rx_byte,
    .mak_valid, .mak_bit, .busy, .status_in, .mem_rd_data, .sak, .state_o, .rd_addr,
    .tx_data, .ld_valid, .ld_addr, .ld_data, .op_valid, .op_code, .op_data);

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s act=%0h exp=%0h", r, act, exp); end
  endtask
  task automatic pulse_hdr(); @(negedge clk) hdr_done = 1; @(negedge clk) hdr_done = 0; endtask
  task automatic stby(); @(negedge clk) stby_pulse = 1; @(negedge clk) stby_pulse = 0; endtask
  task automatic put(input logic [7:0] b);
    @(negedge clk) begin rx_valid = 1; rx_byte = b; end
    @(negedge clk) rx_valid = 0;
  endtask
  task automatic ack(input logic m);
    @(negedge clk) begin mak_valid = 1; mak_bit = m; end
    @(negedge clk) mak_valid = 0;
  endtask
  task automatic begin_cmd(input logic [7:0] c);
    stby(); pulse_hdr(); ack(1); put(8'hA0); ack(1); put(c);
  endtask
  function automatic bit is_known(input logic [7:0] c);
    return c inside {8'h03, 8'h06, 8'h6C, 8'h96, 8'h91, 8'h05, 8'h6E, 8'h6D, 8'h67};
  endfunction
  function automatic bit is_single(input logic [7:0] c);
    return c inside {8'h96, 8'h91, 8'h6D, 8'h67};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] codes[9];
    logic [7:0] sops[4];
    int exp_op[4];
    codes = '{8'h03, 8'h06, 8'h6C, 8'h96, 8'h91, 8'h05, 8'h6E, 8'h6D, 8'h67};
    sops = '{8'h96, 8'h91, 8'h6D, 8'h67};
    exp_op = '{1, 2, 4, 5};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset state", state_o, 0);
    chk("R12 reset sak", sak, 0);
    // R13 header slot
    pulse_hdr(); ack(1);
    chk("R13 no sak after header", sak, 0);
    chk("R13 active", state_o, 1);
    stby(); pulse_hdr(); ack(0);
    chk("R11 stop after header idle", state_o, 2);
    // R1 sweep
    for (int d = 0; d < 256; d++) begin
      stby(); pulse_hdr(); ack(1); put(d[7:0]);
      chk("R1 state", state_o, (d == 8'hA0) ? 1 : 2);
      ack(1);
      chk("R1 sak", sak, (d == 8'hA0) ? 1 : 0);
    end
    stby(); pulse_hdr(); ack(1); put(8'hA0); ack(0);
    chk("R11 stop after device sak", sak, 1);
    chk("R11 stop after device standby", state_o, 0);
    // R2 sweep
    for (int c = 0; c < 256; c++) begin
      begin_cmd(c[7:0]);
      chk("R2 state", state_o, is_known(c[7:0]) ? 1 : 2);
      ack(1);
      chk("R2 sak", sak, (is_known(c[7:0]) && !is_single(c[7:0])) ? 1 : 0);
    end
    // R3 busy
    busy = 1;
    for (int i = 0; i < 9; i++) begin
      begin_cmd(codes[i]);
      chk("R3 busy state", state_o, (codes[i] inside {8'h96, 8'h91, 8'h05}) ? 1 : 2);
    end
    busy = 0;
    // R7 single-byte commands
    for (int i = 0; i < 4; i++) begin
      begin_cmd(sops[i]); ack(0);
      chk("R7 sak", sak, 1); chk("R7 op_valid", op_valid, 1);
      chk("R7 op_code", op_code, exp_op[i]); chk("R7 standby", state_o, 0);
      begin_cmd(sops[i]); ack(1);
      chk("R7 cont sak", sak, 0); chk("R7 cont op", op_valid, 0); chk("R7 cont idle", state_o, 2);
    end
    // R4/R5 read with wrap
    begin_cmd(8'h03); ack(1); put(8'h77); ack(1); put(8'hFE); ack(1);
    chk("R4 addr", rd_addr, 8'hFE); chk("R4 data", tx_data, 8'hFE ^ 8'h5A);
    ack(1); chk("R5 sak", sak, 1); chk("R5 incr", rd_addr, 8'hFF);
    ack(1); chk("R5 wrap", rd_addr, 8'h00);
    ack(0); chk("R5 stop incr", rd_addr, 8'h01); chk("R5 standby", state_o, 0);
    begin_cmd(8'h06); ack(1);
    chk("R5 crrd addr", rd_addr, 8'h01); chk("R5 crrd data", tx_data, 8'h01 ^ 8'h5A);
    ack(1); chk("R5 crrd incr", rd_addr, 8'h02);
    stby(); chk("R6 counter kept", rd_addr, 8'h02); chk("R6 standby", state_o, 0);
    // R11 early stops
    begin_cmd(8'h03); ack(1); put(8'h00); ack(0);
    chk("R11 stop after addr sak", sak, 0); chk("R11 stop after addr idle", state_o, 2);
    begin_cmd(8'h6C); ack(0);
    chk("R11 write stop sak", sak, 0); chk("R11 write stop op", op_valid, 0);
    chk("R11 write stop idle", state_o, 2);
    // R10 page write with wrap
    begin_cmd(8'h6C); ack(1); put(8'h00); ack(1); put(8'h3E); ack(1);
    for (int i = 0; i < 4; i++) begin
      put(8'h10 + i[7:0]); ack(i != 3);
      chk("R10 ld_valid", ld_valid, 1);
      chk("R10 ld_addr", ld_addr, 8'h30 | ((8'h0E + i) & 8'h0F));
      chk("R10 ld_data", ld_data, 8'h10 + i);
      chk("R10 sak", sak, 1);
    end
    chk("R10 commit op", op_valid, 1); chk("R10 commit code", op_code, 6);
    chk("R10 standby", state_o, 0);
    begin_cmd(8'h06); ack(1); chk("R10 counter after page wrap", rd_addr, 8'h32);
    // R8 status write
    begin_cmd(8'h6E); ack(1); put(8'h0C); ack(0);
    chk("R8 sak", sak, 1); chk("R8 op", op_valid, 1); chk("R8 code", op_code, 3);
    chk("R8 data", op_data, 8'h0C); chk("R8 standby", state_o, 0);
    begin_cmd(8'h6E); ack(1); put(8'h0C); ack(1);
    chk("R8 cont sak", sak, 0); chk("R8 cont op", op_valid, 0); chk("R8 cont idle", state_o, 2);
    // R9 status read
    status_in = 8'h03; begin_cmd(8'h05); ack(1);
    chk("R9 status", tx_data, 8'h03);
    status_in = 8'h01; @(negedge clk); chk("R9 live", tx_data, 8'h01);
    ack(1); chk("R9 cont sak", sak, 1); chk("R9 active", state_o, 1);
    ack(0); chk("R9 stop sak", sak, 1); chk("R9 standby", state_o, 0);
    // R12 idle ignores, standby restarts directly
    stby(); pulse_hdr(); ack(1); put(8'h55);
    pulse_hdr(); ack(1); chk("R12 idle sak", sak, 0);
    put(8'hA0); ack(1); chk("R12 idle ignore", sak, 0); chk("R12 idle kept", state_o, 2);
    begin_cmd(8'h96); ack(0); chk("R12 clean end", state_o, 0);
    pulse_hdr(); ack(1); put(8'hA0); ack(1);
    chk("R12 restart without pulse", sak, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule